// File: doc/BRIEF.md
# Strided Quadword Address Walker

This block produces the address stream for one interleaved DMA transfer. Memory is addressed in 16-byte quadwords. A single start pulse captures five things: a byte start address, a total quadword count, a packed stride word that holds a run length and a skip length, and the transfer mode. The block then offers one quadword address at a time on a valid/ready port.

Addresses inside a run are consecutive. After a full run, the walker jumps forward over the skipped quadwords and begins the next run. The total count falls only on accepted beats. When it reaches zero, the output goes quiet and a one-cycle done pulse follows. Only the strided mode value starts the walker. A zero run length is reported as a configuration error instead of being walked.

Top module: `ilv_addr_walker`

## Requirements
- R1: A start is accepted only while the walker is idle and the mode input equals 2 (strided). A start with mode 0, 1 or 3 is ignored: no address is offered, no done pulse appears, and the error flag keeps its value.
- R2: In the cycle after an accepted start with non-zero run length and non-zero total, `addr_valid` is high. `addr_out` then equals the start address with its low 4 bits forced to zero.
- R3: Within a run, each accepted beat (`addr_valid` and `addr_ready` both high at a clock edge) advances `addr_out` by 16.
- R4: The run length is taken from bits 23:16 of `stride_word` and the skip length from bits 7:0. The other bits are ignored. The beat that completes a run of run-length quadwords moves the address by 16 × (skip + 1).
- R5: With a skip length of 0, the address stream is contiguous across run boundaries.
- R6: Exactly `total_qw` addresses are issued. While `addr_ready` is low, `addr_valid` stays high and `addr_out` holds its value.
- R7: After the last beat is accepted, `addr_valid` is low from the next cycle, and `done` is high for exactly that one cycle.
- R8: An accepted start with a total of 0 and a non-zero run length offers no address and pulses `done` for one cycle in the following cycle.
- R9: An accepted start with a run length of 0 sets `cfg_err`, offers no address and gives no done pulse. `cfg_err` stays high until the next accepted start with a non-zero run length.
- R10: A start pulse while addresses are being issued is ignored. The running sequence and its done pulse are unchanged.
- R11: After reset, `addr_valid`, `done` and `cfg_err` are low.
- R12: Addresses wrap modulo 2^ADDR_W when a step passes the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled at the clock edge |
| mode | input | 2 | Transfer mode; 2 selects strided walking |
| base_addr | input | ADDR_W | Byte start address, low 4 bits ignored |
| total_qw | input | 16 | Number of quadwords to issue |
| stride_word | input | 32 | Run length in bits 23:16, skip length in bits 7:0 |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr_out | output | ADDR_W | Offered quadword-aligned byte address |
| done | output | 1 | One-cycle pulse at transfer completion |
| cfg_err | output | 1 | Zero run length was requested |

## Verification
The walker is driven with several run/skip shapes. A run of one with skip zero gives a contiguous walk. A run that is longer than the total count never takes a jump. A short run with a large skip lands far from the previous run. A skip that crosses the top of the address space checks the wrap. Each shape is driven under several ready patterns, from never stalling to stalling every other cycle. This separates the count of accepted beats from the count of cycles, and shows that stalls hold the address. A misaligned start address and stride words with junk in the unused bits show that only the named fields steer the walk. Directed cases cover the zero-total and zero-run starts, every non-strided mode, and a start pulse during issue.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int QW_SHIFT = 4;
    localparam int LEN_W    = 8;
    localparam int CNT_W    = 16;
    localparam int RUN_LSB  = 16;
    localparam int SKIP_LSB = 0;

    typedef enum logic [1:0] {
        XM_NORMAL  = 2'd0,
        XM_CHAIN   = 2'd1,
        XM_STRIDED = 2'd2,
        XM_RSVD    = 2'd3
    } xfer_mode_e;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_ISSUE = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] run_len;
        logic [LEN_W-1:0] skip_len;
    } stride_cfg_t;

    function automatic stride_cfg_t unpack_stride(input logic [31:0] w);
        stride_cfg_t c;
        c.run_len  = w[RUN_LSB +: LEN_W];
        c.skip_len = w[SKIP_LSB +: LEN_W];
        return c;
    endfunction

endpackage

// File: rtl/ilv_count_down.sv
module ilv_count_down #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         is_last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - W'(1);
    end

    assign value   = cnt_q;
    assign is_last = (cnt_q == W'(1));

    // R6
    count_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt_q != '0));
endmodule

// File: rtl/ilv_run_tracker.sv
module ilv_run_tracker #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] run_len,
    input  logic          beat,
    output logic          run_end
);
    logic [LW-1:0] left_q;
    logic [LW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            run_q  <= '0;
        end else if (load) begin
            left_q <= run_len;
            run_q  <= run_len;
        end else if (beat) begin
            if (left_q == LW'(1)) left_q <= run_q;
            else                  left_q <= left_q - LW'(1);
        end
    end

    assign run_end = (left_q == LW'(1));

    // R4
    run_left_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        beat |-> (left_q != '0));
endmodule

// File: rtl/ilv_addr_step.sv
module ilv_addr_step #(
    parameter int ADDR_W = 32,
    parameter int LW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LW-1:0]     skip_len,
    input  logic              beat,
    input  logic              run_end,
    output logic [ADDR_W-1:0] addr_out
);
    import ilv_pkg::*;

    localparam int QA_W = ADDR_W - QW_SHIFT;

    logic [QA_W-1:0] qaddr_q;
    logic [LW-1:0]   skip_q;
    logic [QA_W-1:0] step;

    assign step = run_end ? (QA_W'(skip_q) + QA_W'(1)) : QA_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            qaddr_q <= '0;
            skip_q  <= '0;
        end else if (load) begin
            qaddr_q <= base_addr[ADDR_W-1:QW_SHIFT];
            skip_q  <= skip_len;
        end else if (beat) begin
            qaddr_q <= qaddr_q + step;
        end
    end

    assign addr_out = {qaddr_q, {QW_SHIFT{1'b0}}};

    logic unused_low_bits;
    assign unused_low_bits = ^base_addr[QW_SHIFT-1:0];
endmodule

// File: rtl/ilv_addr_walker.sv
module ilv_addr_walker #(
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [1:0]                mode,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic [ilv_pkg::CNT_W-1:0] total_qw,
    input  logic [31:0]               stride_word,
    input  logic                      addr_ready,
    output logic                      addr_valid,
    output logic [ADDR_W-1:0]         addr_out,
    output logic                      done,
    output logic                      cfg_err
);
    import ilv_pkg::*;

    walk_state_e state_q;
    logic        done_q;
    logic        err_q;
    stride_cfg_t scfg;
    logic        accept, good_go, run_go, zero_go, err_go;
    logic        beat, last_beat, run_end, total_last;
    logic [CNT_W-1:0] remaining;

    assign scfg      = unpack_stride(stride_word);
    assign accept    = start && (state_q == WS_IDLE) && (mode == XM_STRIDED);
    assign err_go    = accept && (scfg.run_len == '0);
    assign good_go   = accept && (scfg.run_len != '0);
    assign run_go    = good_go && (total_qw != '0);
    assign zero_go   = good_go && (total_qw == '0);
    assign addr_valid = (state_q == WS_ISSUE);
    assign beat      = addr_valid && addr_ready;
    assign last_beat = beat && total_last;

    ilv_count_down #(.W(CNT_W)) u_total (
        .clk      (clk),
        .rst      (rst),
        .load     (run_go),
        .load_val (total_qw),
        .dec      (beat),
        .value    (remaining),
        .is_last  (total_last)
    );

    ilv_run_tracker #(.LW(LEN_W)) u_run (
        .clk     (clk),
        .rst     (rst),
        .load    (run_go),
        .run_len (scfg.run_len),
        .beat    (beat),
        .run_end (run_end)
    );

    ilv_addr_step #(.ADDR_W(ADDR_W), .LW(LEN_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (run_go),
        .base_addr (base_addr),
        .skip_len  (scfg.skip_len),
        .beat      (beat),
        .run_end   (run_end),
        .addr_out  (addr_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= zero_go || last_beat;
            if (err_go)       err_q <= 1'b1;
            else if (good_go) err_q <= 1'b0;
            case (state_q)
                WS_IDLE:  if (run_go)    state_q <= WS_ISSUE;
                WS_ISSUE: if (last_beat) state_q <= WS_IDLE;
                default:                 state_q <= WS_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign cfg_err = err_q;

    logic unused_stride_bits;
    assign unused_stride_bits = ^{stride_word[31:24], stride_word[15:8], remaining};

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

    // R9
    err_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !addr_valid);

    // R7
    last_beat_done_chk: assert property (@(posedge clk) disable iff (rst)
        last_beat |=> (done && !addr_valid));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !addr_valid);
endmodule

// File: tb/ilv_addr_walker_tb.sv
module ilv_addr_walker_tb;

    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] total;
        logic [31:0] word;
        logic [7:0]  stall;
        logic [31:0] last;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 16'd5, 32'hAB02_CD03, 8'h00, 32'h0000_10A0},
        '{32'h0000_2008, 16'd4, 32'h0001_0000, 8'h55, 32'h0000_2030},
        '{32'h0000_0000, 16'd3, 32'h0004_0009, 8'h00, 32'h0000_0020},
        '{32'h0000_0100, 16'd6, 32'h0003_00FF, 8'h92, 32'h0000_1140},
        '{32'hFFFF_FFF0, 16'd3, 32'h0001_0001, 8'h0F, 32'h0000_0030},
        '{32'h0000_4000, 16'd4, 32'hFF02_FF00, 8'h33, 32'h0000_4030}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [1:0]        mode;
    logic [ADDR_W-1:0] base_addr;
    logic [15:0]       total_qw;
    logic [31:0]       stride_word;
    logic              addr_ready;
    logic              addr_valid;
    logic [ADDR_W-1:0] addr_out;
    logic              done;
    logic              cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ilv_addr_walker #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .base_addr(base_addr), .total_qw(total_qw), .stride_word(stride_word),
        .addr_ready(addr_ready), .addr_valid(addr_valid), .addr_out(addr_out),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic pulse_start(input logic [1:0] m, input logic [31:0] b,
                               input logic [15:0] t, input logic [31:0] w);
        @(negedge clk);
        mode = m; base_addr = b; total_qw = t; stride_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Walks one strided transfer against a model built from R2..R7.
    task automatic run_walk(input vec_t v, input string tag);
        logic [31:0] exp_a;
        logic [31:0] last_seen;
        int left, n, cyc, run_l, skip_l;
        logic rdy;
        run_l  = int'(v.word[23:16]);
        skip_l = int'(v.word[7:0]);
        addr_ready = 1'b0;
        pulse_start(2'd2, v.base, v.total, v.word);
        exp_a = {v.base[31:4], 4'h0};
        left = run_l; n = 0; cyc = 0; last_seen = '0;
        while (n < int'(v.total) && cyc < 2000) begin
            rdy = ~v.stall[cyc % 8];
            addr_ready = rdy;
            check(addr_valid === 1'b1, {"R6 valid during walk ", tag}, addr_valid, 1);
            check(addr_out === exp_a, {"R3/R4 address ", tag}, addr_out, exp_a);
            check(done === 1'b0, {"R7 no early done ", tag}, done, 0);
            last_seen = addr_out;
            @(negedge clk);
            cyc++;
            if (rdy) begin
                n++;
                if (left == 1) begin
                    exp_a = exp_a + 32'((skip_l + 1) * 16);
                    left = run_l;
                end else begin
                    exp_a = exp_a + 32'd16;
                    left--;
                end
            end
        end
        addr_ready = 1'b0;
        check(n == int'(v.total), {"R6 beat count ", tag}, n, v.total);
        check(last_seen === v.last, {"R4 last address ", tag}, last_seen, v.last);
        check(done === 1'b1 && addr_valid === 1'b0, {"R7 done after last ", tag},
              {done, addr_valid}, 2'b10);
        @(negedge clk);
        check(done === 1'b0, {"R7 done one cycle ", tag}, done, 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode = 2'd0; base_addr = '0;
        total_qw = '0; stride_word = '0; addr_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(addr_valid === 1'b0 && done === 1'b0 && cfg_err === 1'b0,
              "R11 reset outputs", {addr_valid, done, cfg_err}, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_walk(VECS[i], $sformatf("vec%0d", i));
        end
        // R5 contiguous (vec1, skip 0) and R12 wrap (vec4) covered above.

        // R1: non-strided modes are ignored
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            pulse_start(2'(m), 32'h3000, 16'd2, 32'h0001_0000);
            check(addr_valid === 1'b0 && done === 1'b0 && cfg_err === 1'b0,
                  $sformatf("R1 mode %0d ignored", m), {addr_valid, done, cfg_err}, 0);
            @(negedge clk);
            check(addr_valid === 1'b0 && done === 1'b0,
                  $sformatf("R1 mode %0d stays idle", m), {addr_valid, done}, 0);
        end

        // R8: zero total completes at once
        pulse_start(2'd2, 32'h3000, 16'd0, 32'h0002_0000);
        check(done === 1'b1 && addr_valid === 1'b0, "R8 zero total done",
              {done, addr_valid}, 2'b10);
        @(negedge clk);
        check(done === 1'b0 && addr_valid === 1'b0, "R8 done single",
              {done, addr_valid}, 0);

        // R9: zero run length
        pulse_start(2'd2, 32'h3000, 16'd4, 32'hAA00_00BB);
        check(cfg_err === 1'b1 && addr_valid === 1'b0 && done === 1'b0,
              "R9 error raised", {cfg_err, addr_valid, done}, 3'b100);
        repeat (3) @(negedge clk);
        check(cfg_err === 1'b1 && addr_valid === 1'b0, "R9 error held",
              {cfg_err, addr_valid}, 2'b10);
        pulse_start(2'd1, 32'h3000, 16'd4, 32'h0001_0000);
        check(cfg_err === 1'b1, "R1 ignored start keeps error", cfg_err, 1);
        addr_ready = 1'b1;
        pulse_start(2'd2, 32'h3040, 16'd1, 32'h0001_0000);
        check(cfg_err === 1'b0 && addr_valid === 1'b1 && addr_out === 32'h3040,
              "R9 error cleared by good start", {cfg_err, addr_valid, addr_out}, {2'b01, 32'h3040});
        @(negedge clk);
        check(done === 1'b1 && addr_valid === 1'b0, "R7 single beat done",
              {done, addr_valid}, 2'b10);
        addr_ready = 1'b0;
        @(negedge clk);

        // R10: start during issue is ignored
        pulse_start(2'd2, 32'h0500, 16'd3, 32'h0008_0000);
        check(addr_out === 32'h0500 && addr_valid === 1'b1, "R2 first address",
              addr_out, 32'h0500);
        mode = 2'd2; base_addr = 32'h9000; total_qw = 16'd1; stride_word = 32'h0001_0005;
        start = 1'b1; addr_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(addr_out === 32'h0510 && addr_valid === 1'b1, "R10 start while busy",
              addr_out, 32'h0510);
        @(negedge clk);
        check(addr_out === 32'h0520 && addr_valid === 1'b1, "R10 sequence continues",
              addr_out, 32'h0520);
        @(negedge clk);
        check(done === 1'b1 && addr_valid === 1'b0, "R10 original done",
              {done, addr_valid}, 2'b10);
        addr_ready = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && addr_valid === 1'b0, "R10 no second walk",
              {done, addr_valid}, 0);

        finish_run();
    end
endmodule